// File: doc/BRIEF.md
# Triple Xorshift Word Generator

This block produces a stream of 16-bit pseudo-random words. Each enabled clock it advances its state once. The advance is three in-place xorshift operations, chained in one cycle with no feedback tap.

- First, the state is XORed with a copy of itself moved right by 7.
- Second, that result is XORed with a copy of itself moved left by 9, keeping only the low 16 bits.
- Third, that result is XORed with a copy of itself moved right by 13.

Every nonzero state lies on a single cycle of 65535 words. Software or a neighbouring block loads a seed and then raises the enable to draw words. The block refuses a zero seed, because zero maps to itself, and puts a fixed nonzero constant in its place. The stored seed is remembered. A one-cycle flag marks the step at which the stream returns to that seed, so a consumer can see each full period.

Top module: `xs_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state becomes `word_o` = 0xACE1 with `wrap_o` = 0. The remembered seed also becomes 0xACE1.
- R2: When `en_i` is high and `load_i` is low, the next `word_o` is the current word after three steps, each using the previous result. Step one is `a = w ^ (w >> 7)`. Step two is `b = a ^ ((a << 9) mod 2^16)`. Step three is `c = b ^ (b >> 13)`.
- R3: When both `en_i` and `load_i` are low, `word_o` holds its value and `wrap_o` is 0 in the next cycle.
- R4: When `load_i` is high with a nonzero `seed_i`, the next `word_o` equals `seed_i` and `wrap_o` is 0, whatever the level of `en_i`. That seed becomes the remembered seed.
- R5: When `load_i` is high with `seed_i` = 0, the next `word_o` is 0xACE1. The remembered seed becomes 0xACE1.
- R6: From any nonzero loaded seed, the word first equals the seed again after exactly 65535 enabled steps.
- R7: `wrap_o` is 1 for exactly the cycle after an enabled step whose new word equals the remembered seed. It is 0 in all other cycles.
- R8: Outside reset, `word_o` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load `seed_i` into the state; takes priority over `en_i` |
| seed_i | input | 16 | Seed value; zero is replaced by 0xACE1 |
| en_i | input | 1 | Advance the state by one triple-xorshift step |
| word_o | output | 16 | Current generator state |
| wrap_o | output | 1 | One-cycle pulse when the state returns to the remembered seed |

## Verification
Assertions inside the RTL check the following on every cycle:
- the state holds while idle;
- a load places the seed, or 0xACE1 for a zero seed;
- the state is never zero;
- the wrap flag only rises on a word equal to the remembered seed, and never for two cycles running.

Only the bench's scenarios can show two further properties. The first is that the word sequence matches the stated order of shifts and directions. The second is that the period is exactly 65535 words, with the wrap flag seen once at its end. The bench walks a full period from a loaded seed and compares a behavioural model on every clock.

// File: rtl/xs_pkg.sv
// Package: shared width, default seed and the fixed shift schedule of the
// triple-xorshift step. Assumes exactly three stages, applied in index order.
package xs_pkg;
    localparam int unsigned XS_W      = 16;
    localparam int unsigned XS_STAGES = 3;
    localparam logic [XS_W-1:0] XS_DEFAULT_SEED = 16'hACE1;
    // Shift amount and direction per stage (1 = left), in application order.
    localparam int unsigned XS_SHIFT [XS_STAGES] = '{7, 9, 13};
    localparam bit          XS_LEFT  [XS_STAGES] = '{1'b0, 1'b1, 1'b0};
endpackage

// File: rtl/xs_stage.sv
// Module: one in-place xorshift, y = a ^ (a shifted by SHIFT).
// Assumes SHIFT < W; a left shift drops the bits moved above W-1.
module xs_stage #(
    parameter int unsigned W     = 16,
    parameter int unsigned SHIFT = 7,
    parameter bit          LEFT  = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    generate
        if (LEFT) begin : g_left
            // Combine with the left-shifted copy, truncated to W bits.
            assign y = a ^ (a << SHIFT);
        end else begin : g_right
            // Combine with the right-shifted copy.
            assign y = a ^ (a >> SHIFT);
        end
    endgenerate
endmodule

// File: rtl/xs_next.sv
// Module: full next-state function; chains the package's stages in order.
// Assumes purely combinational use within one clock cycle.
module xs_next
    import xs_pkg::*;
#(
    parameter int unsigned W = XS_W
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] chain [XS_STAGES+1];

    assign chain[0] = cur_i;

    // Each stage feeds on the output of the one before it.
    for (genvar g = 0; g < XS_STAGES; g++) begin : g_stage
        xs_stage #(
            .W    (W),
            .SHIFT(XS_SHIFT[g]),
            .LEFT (XS_LEFT[g])
        ) u_stage (
            .a(chain[g]),
            .y(chain[g+1])
        );
    end

    assign nxt_o = chain[XS_STAGES];
endmodule

// File: rtl/xs_seed_guard.sv
// Module: replaces a zero seed with a fixed nonzero constant.
// Assumes FALLBACK is nonzero; zero would lock the generator.
module xs_seed_guard #(
    parameter int unsigned   W        = 16,
    parameter logic [W-1:0]  FALLBACK = 16'hACE1
) (
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] safe_o
);
    // Pass nonzero seeds through unchanged.
    always_comb safe_o = (seed_i == '0) ? FALLBACK : seed_i;
endmodule

// File: rtl/xs_gen.sv
// Module: 16-bit triple-xorshift word generator with seed load and wrap flag.
// Assumes synchronous active-low reset. Load beats enable. The wrap flag
// compares each new word against the most recently loaded (guarded) seed.
module xs_gen
    import xs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [XS_W-1:0] seed_i,
    input  logic            en_i,
    output logic [XS_W-1:0] word_o,
    output logic            wrap_o
);
    logic [XS_W-1:0] state_q, seed_q, nxt, safe_seed;
    logic            wrap_q;

    xs_next #(.W(XS_W)) u_next (
        .cur_i(state_q),
        .nxt_o(nxt)
    );

    xs_seed_guard #(.W(XS_W), .FALLBACK(XS_DEFAULT_SEED)) u_guard (
        .seed_i(seed_i),
        .safe_o(safe_seed)
    );

    // State, remembered seed and wrap pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_DEFAULT_SEED;
            seed_q  <= XS_DEFAULT_SEED;
            wrap_q  <= 1'b0;
        end else if (load_i) begin
            state_q <= safe_seed;
            seed_q  <= safe_seed;
            wrap_q  <= 1'b0;
        end else if (en_i) begin
            state_q <= nxt;
            wrap_q  <= (nxt == seed_q);
        end else begin
            wrap_q  <= 1'b0;
        end
    end

    assign word_o = state_q;
    assign wrap_o = wrap_q;

    // Idle cycles leave the word untouched.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> ($stable(word_o) && !wrap_o));

    // A nonzero seed appears on the word one cycle after load.
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (word_o == $past(seed_i) && !wrap_o));

    // A zero seed is swapped for the default constant.
    assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (word_o == XS_DEFAULT_SEED));

    // The wrap pulse only marks a return to the remembered seed.
    assert_wrap_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (word_o == seed_q));

    // The wrap pulse lasts a single cycle.
    assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

    // The generator never falls into the zero state.
    assert_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_o != '0);
endmodule

// File: tb/sim_xs_gen.sv
// Bench: behavioural reference model compared against the DUT every clock.
module sim_xs_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] seed_i = 16'h0;
    logic        en_i = 1'b0;
    logic [15:0] word_o;
    logic        wrap_o;

    int checks = 0;
    int errors = 0;

    int m_word, m_seed;
    bit m_wrap;

    always #10 clk = ~clk;

    xs_gen u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
        .en_i(en_i), .word_o(word_o), .wrap_o(wrap_o)
    );

    // Spec step: three xorshifts on an integer, masked to 16 bits.
    function automatic int spec_step(input int w);
        int v;
        v = w;
        v = v ^ (v >> 7);
        v = (v ^ (v << 9)) & 32'hFFFF;
        v = v ^ (v >> 13);
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: advance the model with the applied inputs, then compare.
    task automatic tick(input string tag);
        int n;
        @(posedge clk);
        if (!rst_n) begin
            m_word = 16'hACE1; m_seed = 16'hACE1; m_wrap = 0;
        end else if (load_i) begin
            m_word = (seed_i == 0) ? 16'hACE1 : int'(seed_i);
            m_seed = m_word; m_wrap = 0;
        end else if (en_i) begin
            n = spec_step(m_word);
            m_wrap = (n == m_seed);
            m_word = n;
        end else begin
            m_wrap = 0;
        end
        @(negedge clk);
        check({tag, " word"}, int'(word_o), m_word);
        check({tag, " wrap R7"}, int'(wrap_o), int'(m_wrap));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int steps, wraps;
        // R1: reset state.
        repeat (3) tick("R1");
        rst_n = 1'b1;
        // R2: free running.
        en_i = 1'b1;
        repeat (20) tick("R2");
        // R3: hold with enable low, mixed with steps.
        en_i = 1'b0;
        repeat (5) tick("R3");
        for (int i = 0; i < 12; i++) begin
            en_i = (i % 3) != 0;
            tick("R2/R3");
        end
        // R4: load beats enable.
        load_i = 1'b1; seed_i = 16'hBEEF; en_i = 1'b1;
        tick("R4");
        load_i = 1'b0;
        repeat (6) tick("R2");
        load_i = 1'b1; seed_i = 16'h8000; en_i = 1'b0;
        tick("R4");
        load_i = 1'b0; en_i = 1'b1;
        repeat (6) tick("R2");
        // R5: zero seed replaced.
        load_i = 1'b1; seed_i = 16'h0000;
        tick("R5");
        load_i = 1'b0;
        repeat (4) tick("R5");
        // R6/R7: full period from a fresh seed.
        load_i = 1'b1; seed_i = 16'h0001;
        tick("R6");
        load_i = 1'b0; en_i = 1'b1;
        steps = 0; wraps = 0;
        for (int i = 0; i < 65535; i++) begin
            tick("R6");
            steps++;
            if (wrap_o) wraps++;
            check("R8 nonzero", int'(word_o != 16'h0), 1);
            if (word_o == 16'h0001 && i != 65534)
                check("R6 early return", i, 65534);
        end
        check("R6 period end", int'(word_o), 16'h0001);
        check("R7 single wrap", wraps, 1);
        check("R7 wrap at end", int'(wrap_o), 1);
        tick("R7");
        check("R7 pulse ends", int'(wrap_o), 0);
        // R1 again: reset mid-run.
        rst_n = 1'b0;
        tick("R1");
        rst_n = 1'b1;
        repeat (3) tick("R2");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule